// File: doc/BRIEF.md
# LMS Eigenvector Tracking Stage with Deflation

This block is a single stage of an adaptive tracker that follows one singular component of a 4x4 complex channel. Each time a new 4-element complex observation vector is presented, the stage refines its internal complex weight vector with an LMS-type recursion. The recursion uses the observation, the weight from the previous vector and the previous eigenvalue estimate. It then recomputes the eigenvalue estimate as the squared norm of the refreshed weight, forms the normalized singular vector, and subtracts its own component from the observation. The result of that subtraction is the input for a following stage that tracks the next component.

All arithmetic is Q2.13 fixed point on 16-bit signed real and imaginary parts. One signed 16x16 multiplier and a 40-bit accumulator pair are shared across the whole computation in a fixed schedule. A 16-step restoring divider produces one reciprocal of the eigenvalue per vector, and both the singular vector and the deflation term are formed by multiplying with that reciprocal. The step size is a power of two, supplied as a right-shift amount with each vector.

Top module: `lms_eigen_stage`

## Requirements
- R1: After reset, sigma_sq reads 8192 (1.0), done and err are 0, u_out and y_defl are zero, and the internal weight is 1.0 in the real part of element 0 and zero everywhere else.
- R2: Element i of y_in, u_out and y_defl holds its real part in bits [32i+15:32i] and its imaginary part in bits [32i+31:32i+16]. Every sum of products is accumulated at full width, rounded by adding 4096 and shifting right arithmetically by 13, then saturated to [-32768, 32767].
- R3: With p = rounded(y^H·w_old), each element is updated as w_i = sat(w_i + (g_i >>> mu_shift)), where g_i = rounded(y_i·p − sigma_old·w_i) and sigma_old is the estimate left by the previous vector.
- R4: sigma_sq becomes the rounded sum of squares of all real and imaginary parts of the updated weight, and is never negative.
- R5: The reciprocal r equals floor(2^26 / sigma_sq) when sigma_sq > 2048, and 32767 otherwise. Each part of u_out is the rounded product of the matching updated weight part and r.
- R6: With q = rounded(w^H·y) on the updated weight and t = rounded(q·r), each element of y_defl is sat(y_i − rounded(w_i·t)).
- R7: err is 1 for a vector exactly when its sigma_sq is zero or negative, and keeps that value until the next vector's result replaces it.
- R8: y_in and mu_shift are read only at the edge that accepts start while the stage is idle. A start raised while a vector is in progress is ignored, and done is high for exactly one cycle per accepted start.
- R9: done is high after the 106th rising edge that follows the edge accepting start, and all outputs are final at that point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Accepts y_in and mu_shift when the stage is idle |
| y_in | input | 128 | Observation vector, four complex Q2.13 elements |
| mu_shift | input | 4 | Step size as a right-shift amount (mu = 2^-mu_shift) |
| sigma_sq | output | 16 | Eigenvalue estimate, Q2.13 |
| u_out | output | 128 | Normalized singular vector, four complex Q2.13 elements |
| y_defl | output | 128 | Deflated vector for the next stage |
| done | output | 1 | One-cycle pulse when results are valid |
| err | output | 1 | Eigenvalue of the last vector was zero or negative |

## Verification
The hardest case to reach from the ports is a vanishing eigenvalue, where the reciprocal must saturate and err must rise. Random tracking never drives the weight to zero. To get there, the bench resets the stage to its unit weight and unit eigenvalue and then feeds an all-zero vector with shift 0, so the update cancels the weight exactly. The neighbouring small-eigenvalue case reuses that approach with shift 1, which halves the weight and lands sigma_sq exactly on the 2048 saturation threshold. A start pulse with different data is also injected in the middle of one computation to show that it is ignored.

// File: rtl/lms_eigen_stage.sv
module lms_eigen_stage #(
  parameter int W  = 16,
  parameter int FB = 13,
  parameter int AW = 40
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [8*W-1:0] y_in,
  input  logic [3:0]     mu_shift,
  output logic [W-1:0]   sigma_sq,
  output logic [8*W-1:0] u_out,
  output logic [8*W-1:0] y_defl,
  output logic           done,
  output logic           err
);
  localparam int N  = 4;
  localparam int PW = 2*W;
  localparam int TB = $clog2(W);
  localparam logic signed [W-1:0]  ONE    = W'(1 << FB);
  localparam logic signed [W-1:0]  SMAX   = W'((1 << (W-1)) - 1);
  localparam logic signed [W-1:0]  SIG_LO = W'(1 << (2*FB-W+1));
  localparam logic signed [AW-1:0] HALF   = AW'(1 << (FB-1));
  localparam logic signed [AW-1:0] AMAX   = AW'((1 << (W-1)) - 1);
  localparam logic signed [AW-1:0] AMIN   = -AMAX - AW'(1);
  localparam logic [PW-1:0]        NUM    = PW'(1) << (2*FB);

  typedef enum logic [3:0] {
    PH_IDLE, PH_DOT1, PH_UPD, PH_NORM, PH_DIV, PH_U, PH_DOT2, PH_T, PH_DEF
  } ph_t;

  function automatic logic signed [W-1:0] rnd(input logic signed [AW-1:0] x);
    logic signed [AW-1:0] t;
    t = (x + HALF) >>> FB;
    if (t > AMAX) return SMAX;
    if (t < AMIN) return {1'b1, {(W-1){1'b0}}};
    return t[W-1:0];
  endfunction

  function automatic logic signed [W-1:0] sat1(input logic signed [W:0] x);
    if (x[W] != x[W-1]) return x[W] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
    return x[W-1:0];
  endfunction

  ph_t ph;
  logic signed [W-1:0] yr [N];
  logic signed [W-1:0] yi [N];
  logic signed [W-1:0] wr [N];
  logic signed [W-1:0] wi [N];
  logic signed [W-1:0] ur [N];
  logic signed [W-1:0] ui [N];
  logic signed [W-1:0] dr [N];
  logic signed [W-1:0] di [N];
  logic signed [W-1:0] pr, pim, qr, qim, tr, tim, sig, rcp;
  logic [3:0]          mu_q;
  logic [1:0]          el;
  logic [TB-1:0]       tm, tlast, sh;
  logic signed [AW-1:0] acr, aci, acr_n, aci_n, sp;
  logic signed [PW-1:0] prod;
  logic signed [W-1:0] opa, opb, rr, ri, gr_s, gi_s;
  logic [PW-1:0]       rem, rem_n, trial;
  logic [W-1:0]        quo, quo_n;
  logic                to_im, neg, dotm, one_el, clr, last_t, fin, grp, ge;

  always_comb begin
    opa = '0; opb = '0; to_im = 1'b0; neg = 1'b0;
    dotm = 1'b0; one_el = 1'b0; tlast = '0;
    case (ph)
      PH_DOT1: begin
        dotm = 1'b1; tlast = TB'(3);
        case (tm)
          0:       begin opa = yr[el]; opb = wr[el]; end
          1:       begin opa = yi[el]; opb = wi[el]; end
          2:       begin opa = yr[el]; opb = wi[el]; to_im = 1'b1; end
          default: begin opa = yi[el]; opb = wr[el]; to_im = 1'b1; neg = 1'b1; end
        endcase
      end
      PH_UPD: begin
        tlast = TB'(5);
        case (tm)
          0:       begin opa = yr[el]; opb = pr; end
          1:       begin opa = yi[el]; opb = pim; neg = 1'b1; end
          2:       begin opa = sig; opb = wr[el]; neg = 1'b1; end
          3:       begin opa = yr[el]; opb = pim; to_im = 1'b1; end
          4:       begin opa = yi[el]; opb = pr; to_im = 1'b1; end
          default: begin opa = sig; opb = wi[el]; to_im = 1'b1; neg = 1'b1; end
        endcase
      end
      PH_NORM: begin
        dotm = 1'b1; tlast = TB'(1);
        if (tm == '0) begin opa = wr[el]; opb = wr[el]; end
        else          begin opa = wi[el]; opb = wi[el]; end
      end
      PH_DIV: begin
        one_el = 1'b1; tlast = TB'(W-1);
      end
      PH_U: begin
        tlast = TB'(1);
        if (tm == '0) begin opa = wr[el]; opb = rcp; end
        else          begin opa = wi[el]; opb = rcp; to_im = 1'b1; end
      end
      PH_DOT2: begin
        dotm = 1'b1; tlast = TB'(3);
        case (tm)
          0:       begin opa = wr[el]; opb = yr[el]; end
          1:       begin opa = wi[el]; opb = yi[el]; end
          2:       begin opa = wr[el]; opb = yi[el]; to_im = 1'b1; end
          default: begin opa = wi[el]; opb = yr[el]; to_im = 1'b1; neg = 1'b1; end
        endcase
      end
      PH_T: begin
        one_el = 1'b1; tlast = TB'(1);
        if (tm == '0) begin opa = qr; opb = rcp; end
        else          begin opa = qim; opb = rcp; to_im = 1'b1; end
      end
      PH_DEF: begin
        tlast = TB'(3);
        case (tm)
          0:       begin opa = wr[el]; opb = tr; end
          1:       begin opa = wi[el]; opb = tim; neg = 1'b1; end
          2:       begin opa = wr[el]; opb = tim; to_im = 1'b1; end
          default: begin opa = wi[el]; opb = tr; to_im = 1'b1; end
        endcase
      end
      default: ;
    endcase
  end

  assign prod   = opa * opb;
  assign sp     = neg ? -AW'(prod) : AW'(prod);
  assign clr    = (dotm ? (el == 2'd0) : 1'b1) && (tm == '0);
  assign acr_n  = (clr ? AW'(0) : acr) + (to_im ? AW'(0) : sp);
  assign aci_n  = (clr ? AW'(0) : aci) + (to_im ? sp : AW'(0));
  assign last_t = (tm == tlast);
  assign fin    = last_t && (one_el || el == 2'd3);
  assign grp    = dotm ? fin : last_t;
  assign rr     = rnd(acr_n);
  assign ri     = rnd(aci_n);
  assign gr_s   = rr >>> mu_q;
  assign gi_s   = ri >>> mu_q;

  assign sh     = TB'(W-1) - tm;
  assign trial  = PW'($unsigned(sig)) << sh;
  assign ge     = (rem >= trial);
  assign rem_n  = ge ? rem - trial : rem;
  assign quo_n  = quo | (W'(ge) << sh);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= PH_IDLE; el <= '0; tm <= '0; acr <= '0; aci <= '0;
      for (int i = 0; i < N; i++) begin
        yr[i] <= '0; yi[i] <= '0; wi[i] <= '0;
        ur[i] <= '0; ui[i] <= '0; dr[i] <= '0; di[i] <= '0;
        wr[i] <= (i == 0) ? ONE : '0;
      end
      pr <= '0; pim <= '0; qr <= '0; qim <= '0; tr <= '0; tim <= '0;
      sig <= ONE; rcp <= '0; rem <= '0; quo <= '0; mu_q <= '0;
      done <= 1'b0; err <= 1'b0;
    end else begin
      done <= 1'b0;
      if (ph == PH_IDLE) begin
        if (start) begin
          for (int i = 0; i < N; i++) begin
            yr[i] <= y_in[2*W*i +: W];
            yi[i] <= y_in[2*W*i+W +: W];
          end
          mu_q <= mu_shift;
          ph <= PH_DOT1; el <= '0; tm <= '0;
        end
      end else begin
        acr <= acr_n;
        aci <= aci_n;
        if (ph == PH_DIV) begin
          rem <= rem_n;
          quo <= quo_n;
        end
        if (grp) begin
          case (ph)
            PH_DOT1: begin pr <= rr; pim <= ri; end
            PH_UPD: begin
              wr[el] <= sat1((W+1)'(wr[el]) + (W+1)'(gr_s));
              wi[el] <= sat1((W+1)'(wi[el]) + (W+1)'(gi_s));
            end
            PH_NORM: begin sig <= rr; rem <= NUM; quo <= '0; end
            PH_DIV: begin
              rcp <= (sig <= SIG_LO) ? SMAX : $signed(quo_n);
              err <= (sig <= 0);
            end
            PH_U:    begin ur[el] <= rr; ui[el] <= ri; end
            PH_DOT2: begin qr <= rr; qim <= ri; end
            PH_T:    begin tr <= rr; tim <= ri; end
            PH_DEF: begin
              dr[el] <= sat1((W+1)'(yr[el]) - (W+1)'(rr));
              di[el] <= sat1((W+1)'(yi[el]) - (W+1)'(ri));
            end
            default: ;
          endcase
        end
        if (fin) begin
          el <= '0; tm <= '0;
          case (ph)
            PH_DOT1: ph <= PH_UPD;
            PH_UPD:  ph <= PH_NORM;
            PH_NORM: ph <= PH_DIV;
            PH_DIV:  ph <= PH_U;
            PH_U:    ph <= PH_DOT2;
            PH_DOT2: ph <= PH_T;
            PH_T:    ph <= PH_DEF;
            default: begin ph <= PH_IDLE; done <= 1'b1; end
          endcase
        end else if (last_t) begin
          tm <= '0; el <= el + 2'd1;
        end else begin
          tm <= tm + TB'(1);
        end
      end
    end
  end

  assign sigma_sq = sig;
  for (genvar i = 0; i < N; i++) begin : g_pack
    assign u_out[2*W*i +: W]    = ur[i];
    assign u_out[2*W*i+W +: W]  = ui[i];
    assign y_defl[2*W*i +: W]   = dr[i];
    assign y_defl[2*W*i+W +: W] = di[i];
  end

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_busy_holds_input_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ph != PH_IDLE) |=> ($stable(yr[0]) && $stable(yi[3]) && $stable(mu_q)));

  assert_recip_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_U && sig > SIG_LO) |->
      ((int'(rcp) * int'(sig) <= (1 << (2*FB))) &&
       ((int'(rcp) + 1) * int'(sig) > (1 << (2*FB)))));

  assert_err_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (err == (sig <= 0)));

  assert_sigma_nonneg_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_DIV) |-> !sig[W-1]);

endmodule

// File: tb/lms_eigen_stage_test.sv
module lms_eigen_stage_test;
  localparam int CLK_NS = 10;
  localparam int LAT    = 107;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [127:0] y_in = '0;
  logic [3:0]   mu_shift = '0;
  logic [15:0]  sigma_sq;
  logic [127:0] u_out, y_defl;
  logic         done, err;

  lms_eigen_stage uut (
    .clk(clk), .rst_n(rst_n), .start(start), .y_in(y_in), .mu_shift(mu_shift),
    .sigma_sq(sigma_sq), .u_out(u_out), .y_defl(y_defl), .done(done), .err(err)
  );

  always #(CLK_NS/2) clk = ~clk;

  int n_chk = 0, n_err = 0;
  int mwr[4], mwi[4], ms;
  int esig, eerr;
  int eur[4], eui[4], edr[4], edi[4];

  function automatic int sat(longint x);
    if (x > 32767) return 32767;
    if (x < -32768) return -32768;
    return int'(x);
  endfunction

  function automatic int rnd(longint x);
    return sat((x + 4096) >>> 13);
  endfunction

  function automatic int fld(logic [127:0] v, int i, int im);
    return int'($signed(v[32*i+16*im +: 16]));
  endfunction

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin mwr[i] = 0; mwi[i] = 0; end
    mwr[0] = 8192;
    ms = 8192;
  endtask

  task automatic model_step(input int yr[4], input int yi[4], input int mu);
    longint ar, ai;
    int p_r, p_i, gr, gi, r, q_r, q_i, t_r, t_i;
    ar = 0; ai = 0;
    for (int i = 0; i < 4; i++) begin
      ar += longint'(yr[i]) * mwr[i] + longint'(yi[i]) * mwi[i];
      ai += longint'(yr[i]) * mwi[i] - longint'(yi[i]) * mwr[i];
    end
    p_r = rnd(ar); p_i = rnd(ai);
    for (int i = 0; i < 4; i++) begin
      gr = rnd(longint'(yr[i]) * p_r - longint'(yi[i]) * p_i - longint'(ms) * mwr[i]);
      gi = rnd(longint'(yr[i]) * p_i + longint'(yi[i]) * p_r - longint'(ms) * mwi[i]);
      mwr[i] = sat(longint'(mwr[i]) + (gr >>> mu));
      mwi[i] = sat(longint'(mwi[i]) + (gi >>> mu));
    end
    ar = 0;
    for (int i = 0; i < 4; i++) ar += longint'(mwr[i]) * mwr[i] + longint'(mwi[i]) * mwi[i];
    ms = rnd(ar);
    r = (ms <= 2048) ? 32767 : 67108864 / ms;
    eerr = (ms <= 0) ? 1 : 0;
    esig = ms;
    ar = 0; ai = 0;
    for (int i = 0; i < 4; i++) begin
      eur[i] = rnd(longint'(mwr[i]) * r);
      eui[i] = rnd(longint'(mwi[i]) * r);
      ar += longint'(mwr[i]) * yr[i] + longint'(mwi[i]) * yi[i];
      ai += longint'(mwr[i]) * yi[i] - longint'(mwi[i]) * yr[i];
    end
    q_r = rnd(ar); q_i = rnd(ai);
    t_r = rnd(longint'(q_r) * r); t_i = rnd(longint'(q_i) * r);
    for (int i = 0; i < 4; i++) begin
      edr[i] = sat(longint'(yr[i]) - rnd(longint'(mwr[i]) * t_r - longint'(mwi[i]) * t_i));
      edi[i] = sat(longint'(yi[i]) - rnd(longint'(mwr[i]) * t_i + longint'(mwi[i]) * t_r));
    end
  endtask

  task automatic run_vec(input int yr[4], input int yi[4], input int mu, input bit poke);
    logic [127:0] v;
    int cyc;
    for (int i = 0; i < 4; i++) begin
      v[32*i +: 16]    = 16'(yr[i]);
      v[32*i+16 +: 16] = 16'(yi[i]);
    end
    @(negedge clk);
    y_in = v; mu_shift = 4'(mu); start = 1'b1;
    model_step(yr, yi, mu);
    cyc = 0;
    while (1) begin
      @(negedge clk);
      cyc++;
      start = 1'b0;
      if (poke && cyc == 40) begin start = 1'b1; y_in = ~v; mu_shift = 4'd0; end
      if (poke && cyc == 41) y_in = v ^ 128'h1234;
      if (done || cyc > 1000) break;
    end
    check("R9", "done latency", cyc, LAT);
    check("R4", "sigma_sq", int'($signed(sigma_sq)), esig);
    check("R7", "err", int'(err), eerr);
    for (int i = 0; i < 4; i++) begin
      check("R2,R3,R5", "u real", fld(u_out, i, 0), eur[i]);
      check("R2,R3,R5", "u imag", fld(u_out, i, 1), eui[i]);
      check("R2,R6", "deflated real", fld(y_defl, i, 0), edr[i]);
      check("R2,R6", "deflated imag", fld(y_defl, i, 1), edi[i]);
    end
    @(negedge clk);
    check("R8", "done width", int'(done), 0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; start = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "reset sigma_sq", int'(sigma_sq), 8192);
    check("R1", "reset done", int'(done), 0);
    check("R1", "reset err", int'(err), 0);
    check("R1", "reset u_out zero", int'(u_out == '0), 1);
    check("R1", "reset y_defl zero", int'(y_defl == '0), 1);
    rst_n = 1'b1;
    model_reset();
  endtask

  initial begin
    #(CLK_NS * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog: run did not finish actual=hung expected=finished");
    report();
    $finish;
  end

  initial begin
    int yr[4], yi[4];
    void'($urandom(32'd71377));
    do_reset();

    for (int i = 0; i < 4; i++) begin yr[i] = 0; yi[i] = 0; end
    run_vec(yr, yi, 1, 1'b0);
    check("R5", "sigma at saturation threshold", int'(sigma_sq), 2048);
    check("R5", "u at saturated reciprocal", fld(u_out, 0, 0), 16384);

    yr[0] = 4096; yi[0] = 0; yr[1] = -2048; yi[1] = 1024; yr[2] = 0; yi[2] = 3000; yr[3] = 100; yi[3] = -100;
    run_vec(yr, yi, 2, 1'b0);

    for (int k = 0; k < 256; k++) begin
      for (int i = 0; i < 4; i++) begin
        yr[i] = int'($urandom_range(8191, 0)) - 4096;
        yi[i] = int'($urandom_range(8191, 0)) - 4096;
      end
      run_vec(yr, yi, int'($urandom_range(6, 1)), (k == 5 || k == 100));
    end

    do_reset();
    for (int i = 0; i < 4; i++) begin yr[i] = 0; yi[i] = 0; end
    run_vec(yr, yi, 0, 1'b0);
    check("R7", "zero weight raises err", int'(err), 1);
    check("R4", "zero weight sigma", int'(sigma_sq), 0);
    yr[0] = 2000; yi[2] = -1500;
    run_vec(yr, yi, 3, 1'b0);
    do_reset();

    report();
    $finish;
  end
endmodule